// File: doc/BRIEF.md
# Receive Character Timeout Timer

This block sits beside a UART receive FIFO. It raises a timeout request when characters are waiting in the FIFO, no new character has arrived, and the processor has not read the FIFO for four whole character times. Software then knows to drain a partial FIFO that never reached its trigger level. The timer counts ticks of a 16x oversampled baud clock, so the delay follows the baud rate. The length of one character time comes from the programmed frame format.

The control is a three-state machine:
- `ST_IDLE`: the FIFO is empty and the counter is held at zero.
- `ST_TIMING`: the FIFO holds data and the counter advances on each baud tick.
- `ST_PENDING`: a timeout has fired.

Transitions:
- idle-to-timing: the FIFO level becomes non-zero.
- timing-to-idle: the FIFO empties.
- timing restart: a received-character strobe or a processor-read strobe clears the counter and stays in `ST_TIMING`.
- timing-to-pending: the tick that completes four character times.
- pending-to-timing: a processor read clears the counter.
- pending-to-idle: the FIFO empties.

The output request is `ST_PENDING` qualified by the FIFO enable and the receive-interrupt enable. It is meant to share priority with the received-data-available interrupt in the interrupt logic.

Top module: `rxto_timer`

## Requirements
- R1: While reset is asserted and right after it, `timeout_irq` is 0 and the timer is cleared.
- R2: One character time is 16 baud ticks per frame bit. The frame bits are one start bit, plus data bits, plus one bit if `parity_en`=1, plus one stop bit, plus one more if `two_stop`=1. The data bits are 5, 6, 7 and 8 for `data_len` codes 0, 1, 2 and 3.
- R3: With the FIFO level non-zero and no strobes, `timeout_irq` rises on the clock edge that takes the 4×(character time)-th baud tick counted from entry to `ST_TIMING`. It is still 0 one tick earlier.
- R4: While `fifo_level` is 0 no timeout is produced, whatever the number of ticks. A FIFO that empties while pending drops the request on the next edge.
- R5: The counter advances only on cycles with `baud_tick`=1.
- R6: While not pending, `rx_char_stb` clears the counter, so a full four character times must pass again.
- R7: While not pending, `cpu_rd_stb` clears the counter in the same way.
- R8: While pending, `rx_char_stb` leaves the request set. `cpu_rd_stb` clears the request on the next edge and restarts the count.
- R9: `timeout_irq` is 0 whenever `fifo_en`=0 or `rx_int_en`=0. The pending state survives underneath and shows again once both enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | 16x oversampled baud tick, one cycle wide |
| data_len | input | 2 | Data bit count code (0..3 → 5..8 bits) |
| parity_en | input | 1 | Parity bit present in frame |
| two_stop | input | 1 | Second stop bit present in frame |
| fifo_en | input | 1 | FIFO mode enable |
| rx_int_en | input | 1 | Receive-data interrupt enable |
| fifo_level | input | 5 | Receive FIFO occupancy |
| rx_char_stb | input | 1 | A character was written into the FIFO |
| cpu_rd_stb | input | 1 | The processor read one character from the FIFO |
| timeout_irq | output | 1 | Character timeout request |

## Verification
The bench builds the block with its defaults: 16x oversampling, a four-character window and a 16-entry FIFO. This gives a 10-bit counter and limits from 448 to 768 ticks. Driving `baud_tick` high every cycle brings even the 12-bit-frame limit within a few hundred cycles. Each frame format can therefore be checked at the exact tick of expiry and the tick before it. The same speed leaves room to hold the line idle for thousands of cycles, which shows that an empty FIFO or an absent tick produces no timeout.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_TIMING  = 2'd1,
        ST_PENDING = 2'd2
    } rxto_state_e;

    // Frame bits: start + 5 data + 1 stop = 7, plus the optional pieces
    localparam int unsigned BASE_FRAME_BITS = 7;
    localparam int unsigned MAX_FRAME_BITS  = 12;
endpackage

// File: rtl/rxto_frame_len.sv
module rxto_frame_len #(
    parameter int unsigned OSR       = 16,
    parameter int unsigned NUM_CHARS = 4,
    parameter int unsigned CNT_W     = 10
) (
    input  logic [1:0]       data_len,
    input  logic             parity_en,
    input  logic             two_stop,
    output logic [CNT_W-1:0] limit
);
    import rxto_pkg::*;

    localparam int unsigned UNIT = OSR * NUM_CHARS;

    logic [3:0] frame_bits;

    always_comb begin
        frame_bits = 4'(BASE_FRAME_BITS) + {2'b00, data_len}
                   + {3'b000, parity_en} + {3'b000, two_stop};
        limit      = CNT_W'(UNIT) * CNT_W'(frame_bits);
    end
endmodule

// File: rtl/rxto_ctrl.sv
module rxto_ctrl #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             has_data,
    input  logic             rx_char_stb,
    input  logic             cpu_rd_stb,
    input  logic             fifo_en,
    input  logic             rx_int_en,
    input  logic [CNT_W-1:0] limit,
    output logic             timeout_irq
);
    import rxto_pkg::*;

    rxto_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             pending;

    // Next-state and counter update
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (has_data) state_d = ST_TIMING;
            end
            ST_TIMING: begin
                if (!has_data) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (rx_char_stb || cpu_rd_stb) begin
                    cnt_d = '0;
                end else if (baud_tick) begin
                    if (cnt_q + CNT_W'(1) >= limit) begin
                        state_d = ST_PENDING;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            ST_PENDING: begin
                cnt_d = '0;
                if (!has_data)       state_d = ST_IDLE;
                else if (cpu_rd_stb) state_d = ST_TIMING;
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        pending     = (state_q == ST_PENDING);
        timeout_irq = pending && fifo_en && rx_int_en;
    end

    // R3
    fire_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> ($past(baud_tick) && ($past(cnt_q) + CNT_W'(1) >= $past(limit))));

    // R4
    empty_goes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !has_data |=> (state_q == ST_IDLE));

    // R5
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TIMING && has_data && !baud_tick && !rx_char_stb && !cpu_rd_stb)
        |=> $stable(cnt_q));

    // R6
    restart_on_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TIMING && (rx_char_stb || cpu_rd_stb)) |=> (cnt_q == '0));

    // R8
    read_clears_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && cpu_rd_stb) |=> !pending);

    // R8
    rx_keeps_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && has_data && !cpu_rd_stb) |=> pending);
endmodule

// File: rtl/rxto_timer.sv
module rxto_timer #(
    parameter int unsigned OSR        = 16,
    parameter int unsigned NUM_CHARS  = 4,
    parameter int unsigned FIFO_DEPTH = 16,
    localparam int unsigned OCC_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic [1:0]       data_len,
    input  logic             parity_en,
    input  logic             two_stop,
    input  logic             fifo_en,
    input  logic             rx_int_en,
    input  logic [OCC_W-1:0] fifo_level,
    input  logic             rx_char_stb,
    input  logic             cpu_rd_stb,
    output logic             timeout_irq
);
    localparam int unsigned CNT_W =
        $clog2(OSR * NUM_CHARS * rxto_pkg::MAX_FRAME_BITS + 1);

    logic [CNT_W-1:0] limit;
    logic             has_data;

    assign has_data = (fifo_level != '0);

    rxto_frame_len #(
        .OSR       (OSR),
        .NUM_CHARS (NUM_CHARS),
        .CNT_W     (CNT_W)
    ) u_frame_len (
        .data_len  (data_len),
        .parity_en (parity_en),
        .two_stop  (two_stop),
        .limit     (limit)
    );

    rxto_ctrl #(
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .baud_tick   (baud_tick),
        .has_data    (has_data),
        .rx_char_stb (rx_char_stb),
        .cpu_rd_stb  (cpu_rd_stb),
        .fifo_en     (fifo_en),
        .rx_int_en   (rx_int_en),
        .limit       (limit),
        .timeout_irq (timeout_irq)
    );

    // R9
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en || !rx_int_en) |-> !timeout_irq);
endmodule

// File: tb/rxto_timer_tb.sv
module rxto_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       baud_tick;
    logic [1:0] data_len;
    logic       parity_en;
    logic       two_stop;
    logic       fifo_en;
    logic       rx_int_en;
    logic [4:0] fifo_level;
    logic       rx_char_stb;
    logic       cpu_rd_stb;
    logic       timeout_irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rxto_timer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .baud_tick   (baud_tick),
        .data_len    (data_len),
        .parity_en   (parity_en),
        .two_stop    (two_stop),
        .fifo_en     (fifo_en),
        .rx_int_en   (rx_int_en),
        .fifo_level  (fifo_level),
        .rx_char_stb (rx_char_stb),
        .cpu_rd_stb  (cpu_rd_stb),
        .timeout_irq (timeout_irq)
    );

    // {data_len, parity_en, two_stop, expected limit in ticks}
    localparam logic [13:0] VEC [6] = '{
        {2'd0, 1'b0, 1'b0, 10'd448},
        {2'd3, 1'b0, 1'b0, 10'd640},
        {2'd3, 1'b1, 1'b1, 10'd768},
        {2'd2, 1'b1, 1'b0, 10'd640},
        {2'd1, 1'b0, 1'b1, 10'd576},
        {2'd0, 1'b1, 1'b1, 10'd576}
    };

    task automatic check(input logic exp, input string req);
        n_chk++;
        if (timeout_irq !== exp) begin
            n_fail++;
            $display("FAIL %s: timeout_irq=%b expected %b at %0t", req, timeout_irq, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Empty the FIFO, refill it and enter the timing state with ticks running
    task automatic arm();
        baud_tick = 1'b0; fifo_level = 5'd0;
        step(2);
        fifo_level = 5'd3;
        step(1);
        baud_tick = 1'b1;
    endtask

    task automatic pulse_read();
        cpu_rd_stb = 1'b1; step(1); cpu_rd_stb = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lim;
        rst_n = 1'b0; baud_tick = 1'b1; data_len = 2'd3; parity_en = 1'b0;
        two_stop = 1'b0; fifo_en = 1'b1; rx_int_en = 1'b1; fifo_level = 5'd3;
        rx_char_stb = 1'b0; cpu_rd_stb = 1'b0;
        step(3);
        check(1'b0, "R1 in reset");
        rst_n = 1'b1; baud_tick = 1'b0;
        step(4);
        check(1'b0, "R1 after reset");

        // Frame formats: exact expiry tick
        for (int i = 0; i < 6; i++) begin
            data_len  = VEC[i][13:12];
            parity_en = VEC[i][11];
            two_stop  = VEC[i][10];
            lim       = int'(VEC[i][9:0]);
            arm();
            step(lim - 1);
            check(1'b0, "R2/R3 one tick early");
            step(1);
            check(1'b1, "R2/R3 at limit");
            pulse_read();
            check(1'b0, "R8 read clears");
        end

        // 8N1 for directed tests
        data_len = 2'd3; parity_en = 1'b0; two_stop = 1'b0; lim = 640;

        // R6: received character restarts timer
        arm();
        step(lim - 1);
        rx_char_stb = 1'b1; step(1); rx_char_stb = 1'b0;
        step(lim - 1);
        check(1'b0, "R6 restarted");
        step(1);
        check(1'b1, "R6 fires after restart");

        // R8: received character does not clear pending
        rx_char_stb = 1'b1; step(1); rx_char_stb = 1'b0;
        check(1'b1, "R8 rx strobe keeps pending");

        // R9: gating
        fifo_en = 1'b0; #1;
        check(1'b0, "R9 fifo disabled");
        fifo_en = 1'b1; #1;
        check(1'b1, "R9 fifo re-enabled");
        rx_int_en = 1'b0; step(3);
        check(1'b0, "R9 interrupt disabled");
        rx_int_en = 1'b1; #1;
        check(1'b1, "R9 pending survives");

        // R7: read restarts timer
        pulse_read();
        check(1'b0, "R8 read clears");
        step(lim - 1);
        pulse_read();
        step(lim - 1);
        check(1'b0, "R7 restarted");
        step(1);
        check(1'b1, "R7 fires after restart");
        pulse_read();

        // R5: no tick, no progress
        baud_tick = 1'b0;
        step(2000);
        check(1'b0, "R5 no ticks");
        baud_tick = 1'b1;
        step(lim - 1);
        check(1'b0, "R5 count held");
        step(1);
        check(1'b1, "R5 fires");

        // R4: emptying while pending
        fifo_level = 5'd0;
        step(1);
        check(1'b0, "R4 empty drops pending");
        step(lim + 10);
        check(1'b0, "R4 empty never fires");
        fifo_level = 5'd1;
        step(1);
        check(1'b0, "R4 refill starts fresh");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule